// File: doc/BRIEF.md
# Serial Gain Register Port

This block is the slave side of a three-wire serial control port that owns a single 10-bit gain register. A controller frames each transfer by pulling an active-low load strobe low, then clocks in a direction bit, a 4-bit register address and an 11-bit data field. Every bit is taken on a rising edge of the serial clock. A write does not touch the register while bits are still arriving. The new value is committed only when the load strobe returns high, and only the low 10 data bits are kept. A read turns the data line around after the header and shifts the register contents out, one bit per falling edge of the serial clock.

The serial pins are resampled into the system clock domain, and all edge detection happens there. The bidirectional data pin is split into an input, an output and an output enable, so that the pad's tri-state driver can sit outside the block. After reset the register holds its default value. For a programmable number of system clock cycles after reset, completed write frames are dropped, so that settling circuitry can finish before the gain moves.

Top module: `serial_gain_port`

## Requirements
- R1: After reset is released, `gain_o` reads 0x096, and `sdata_oe` and `sdata_o` are both 0.
- R2: A frame consists of a direction bit (0 = write, 1 = read), then 4 address bits, then 11 data bits. The address and data fields are each sent least significant bit first, and every bit is sampled on a serial clock rising edge while load is low. A complete write frame to address `GAIN_ADDR` (default 0xA) stores data bits 0..9 into `gain_o`, and data bit 10 is discarded.
- R3: `gain_o` does not change while a write frame is shifting in, including after the last bit and before load rises. It takes the new value only after the load rising edge.
- R4: A complete write frame to any address other than `GAIN_ADDR` leaves `gain_o` unchanged.
- R5: In a read frame, `sdata_oe` stays 0 until the 5th serial clock falling edge. From that edge on, `sdata_oe` is 1 and `sdata_o` presents gain bit k after falling edge 5+k (k = 0..9), advancing on each falling edge. Position 10 and any later position read 0, and the register is not modified by the read.
- R6: A read frame to an address other than `GAIN_ADDR` drives `sdata_oe` = 1 with `sdata_o` = 0 at every data position.
- R7: A write frame whose load rising edge falls within `LOCK_CYCLES` system clock cycles after reset release is discarded, and `gain_o` stays at 0x096.
- R8: If load rises before all 16 frame bits have been sampled, the frame is aborted and `gain_o` is unchanged.
- R9: Once load is high, `sdata_oe` returns to 0 and `sdata_o` reads 0.
- R10: Rising edges after the 16th bit of a frame are ignored, and a write still commits the data carried by the first 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| sload_n_i | input | 1 | Active-low frame strobe; its rising edge ends a frame |
| sdata_i | input | 1 | Serial data from the controller |
| sdata_o | output | 1 | Serial readback data toward the pad |
| sdata_oe | output | 1 | Output enable for the data pad driver |
| gain_o | output | GAIN_W | Current gain register value |

## Verification
The hardest situation to reach is the exact turnaround of a read. The data line has to stay released through the first four falling edges, switch on at the fifth, and then advance one bit per falling edge, including the eleventh position past the register width. The stimulus slows the serial clock to several system cycles per phase and samples the pins at the end of every low phase. That way both the still-released header positions and each readback position are checked against a bit computed from the last value the bench wrote. The lockout window is reached by issuing a full, well-formed write immediately after reset, with a value that would be visibly different if it were accepted.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

  typedef enum logic [1:0] {
    SLOT_RNW,
    SLOT_ADDR,
    SLOT_DATA,
    SLOT_OVER
  } slot_e;

  // Number of serial bits in one complete frame.
  function automatic int frame_len(input int aw, input int dw);
    return 1 + aw + dw;
  endfunction

  // Which field a given bit position of the frame belongs to.
  function automatic slot_e slot_of(input int idx, input int aw, input int dw);
    if (idx == 0) return SLOT_RNW;
    if (idx <= aw) return SLOT_ADDR;
    if (idx <= aw + dw) return SLOT_DATA;
    return SLOT_OVER;
  endfunction

endpackage

// File: rtl/sgp_sync.sv
module sgp_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= IDLE;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= IDLE;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sgp_frame.sv
module sgp_frame
  import sgp_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 11,
  parameter int STORE_W = 10,
  localparam int FLEN   = frame_len(ADDR_W, DATA_W),
  localparam int CNT_W  = $clog2(FLEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_hi_i,
  input  logic               sclk_rise_i,
  input  logic               sdata_i,
  output logic               rnw_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [STORE_W-1:0] data_o,
  output logic [CNT_W-1:0]   bits_o,
  output logic               full_o
);

  localparam logic [CNT_W-1:0] FLEN_C = CNT_W'(FLEN);

  logic [CNT_W-1:0]   bits_q;
  logic               rnw_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [STORE_W-1:0] data_q;
  logic               shift_en;
  slot_e              slot_w;

  assign shift_en = sclk_rise_i && !load_hi_i && (bits_q < FLEN_C);
  assign slot_w   = slot_of(int'(bits_q), ADDR_W, DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      rnw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_hi_i) begin
      bits_q <= '0;
    end else if (shift_en) begin
      bits_q <= bits_q + 1'b1;
      case (slot_w)
        SLOT_RNW:  rnw_q  <= sdata_i;
        SLOT_ADDR: addr_q <= {sdata_i, addr_q[ADDR_W-1:1]};
        SLOT_DATA: begin
          for (int k = 0; k < STORE_W; k++) begin
            if (int'(bits_q) == 1 + ADDR_W + k) data_q[k] <= sdata_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign rnw_o  = rnw_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign bits_o = bits_q;
  assign full_o = (bits_q == FLEN_C);

  // R10: surplus rising edges never push the bit count past one frame
  assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= FLEN_C)
    else $error("bit count exceeded frame length");

endmodule

// File: rtl/sgp_readback.sv
module sgp_readback #(
  parameter int REG_W  = 10,
  parameter int DATA_W = 11,
  parameter int HDR    = 5,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_hi_i,
  input  logic             sclk_fall_i,
  input  logic             rnw_i,
  input  logic [CNT_W-1:0] bits_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] reg_i,
  output logic             oe_o,
  output logic             bit_o
);

  localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] REG_C   = IDX_W'(REG_W);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             hdr_done;
  logic [REG_W-1:0] shifted;

  assign hdr_done = rnw_i && (bits_i >= HDR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_hi_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (sclk_fall_i) begin
      if (!active_q && hdr_done) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (active_q && idx_q < IDX_MAX) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign shifted = reg_i >> idx_q;
  assign oe_o    = active_q;
  assign bit_o   = (active_q && sel_i && idx_q < REG_C) ? shifted[0] : 1'b0;

  // R5: the data line is only ever claimed on a serial clock falling edge
  assert_oe_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(sclk_fall_i))
    else $error("readback enabled outside a falling edge");

  // R9: a high load strobe releases the data line on the next cycle
  assert_release_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_hi_i |=> !active_q)
    else $error("data line still driven with load high");

endmodule

// File: rtl/sgp_lockout.sv
module sgp_lockout #(
  parameter int CYCLES = 1000,
  localparam int CW    = $clog2(CYCLES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  output logic done_o
);

  localparam logic [CW-1:0] CYC_C = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CYC_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  // R7: once the settling window is over it stays over
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o)
    else $error("lockout re-entered");

endmodule

// File: rtl/serial_gain_port.sv
module serial_gain_port
  import sgp_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter int              DATA_W      = 11,
  parameter int              GAIN_W      = 10,
  parameter logic [ADDR_W-1:0] GAIN_ADDR = 4'hA,
  parameter logic [GAIN_W-1:0] GAIN_RESET = 10'h096,
  parameter int              LOCK_CYCLES = 1000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sload_n_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic [GAIN_W-1:0] gain_o
);

  localparam int FLEN  = frame_len(ADDR_W, DATA_W);
  localparam int CNT_W = $clog2(FLEN + 1);
  localparam int HDR   = 1 + ADDR_W;

  // synchronized pins: bit 0 serial clock, bit 1 load strobe, bit 2 data
  logic [2:0] pins_s;
  logic [1:0] prev_q;

  logic sclk_rise, sclk_fall, load_hi, load_rise;
  logic rnw_w, frame_full, addr_hit, lock_done, commit_ok;
  logic [ADDR_W-1:0] addr_w;
  logic [GAIN_W-1:0] data_w;
  logic [CNT_W-1:0]  bits_w;
  logic [GAIN_W-1:0] gain_q;

  sgp_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sdata_i, sload_n_i, sclk_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b10;
    else        prev_q <= pins_s[1:0];
  end

  assign sclk_rise = pins_s[0] & ~prev_q[0];
  assign sclk_fall = ~pins_s[0] & prev_q[0];
  assign load_hi   = pins_s[1];
  assign load_rise = pins_s[1] & ~prev_q[1];

  sgp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_W(GAIN_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_hi_i   (load_hi),
    .sclk_rise_i (sclk_rise),
    .sdata_i     (pins_s[2]),
    .rnw_o       (rnw_w),
    .addr_o      (addr_w),
    .data_o      (data_w),
    .bits_o      (bits_w),
    .full_o      (frame_full)
  );

  sgp_lockout #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_o (lock_done)
  );

  assign addr_hit  = (addr_w == GAIN_ADDR);
  assign commit_ok = load_rise && frame_full && !rnw_w && addr_hit && lock_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gain_q <= GAIN_RESET;
    else if (commit_ok) gain_q <= data_w;
  end

  sgp_readback #(.REG_W(GAIN_W), .DATA_W(DATA_W), .HDR(HDR), .CNT_W(CNT_W)) u_read (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_hi_i   (load_hi),
    .sclk_fall_i (sclk_fall),
    .rnw_i       (rnw_w),
    .bits_i      (bits_w),
    .sel_i       (addr_hit),
    .reg_i       (gain_q),
    .oe_o        (sdata_oe),
    .bit_o       (sdata_o)
  );

  assign gain_o = gain_q;

  // R3: the register moves only in the cycle after a load rising edge
  assert_gain_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(gain_q))
    else $error("gain changed without a load rising edge");

  // R7: throughout the settling window the register keeps its default
  assert_lockout_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_done |-> gain_q == GAIN_RESET)
    else $error("gain written during lockout");

  // R8: an incomplete frame never changes the register
  assert_short_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && !frame_full) |=> $stable(gain_q))
    else $error("short frame altered gain");

  // R4: frames addressed elsewhere never change the register
  assert_foreign_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && !addr_hit) |=> $stable(gain_q))
    else $error("foreign address altered gain");

endmodule

// File: tb/tb_serial_gain_port.sv
module tb_serial_gain_port;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int LOCK       = 1000;
  localparam logic [3:0] ADDR = 4'hA;

  typedef struct {
    string       rq;
    int          kind;   // 0: gain_o, 1: {sdata_oe, sdata_o}
    logic [10:0] exp;
  } item_t;

  logic clk, rst_n, sclk, sload_n, sdata;
  logic sdata_o, sdata_oe;
  logic [9:0] gain_o;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic mon_strobe = 1'b0;
  logic [9:0] model_gain;

  serial_gain_port #(.GAIN_ADDR(ADDR), .LOCK_CYCLES(LOCK)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk),
    .sload_n_i (sload_n),
    .sdata_i   (sdata),
    .sdata_o   (sdata_o),
    .sdata_oe  (sdata_oe),
    .gain_o    (gain_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // monitor: pops the expected item and compares just after a falling clock edge
  always @(negedge clk) begin
    item_t it;
    logic [10:0] act;
    #1;
    if (mon_strobe && exp_q.size() > 0) begin
      it = exp_q.pop_front();
      if (it.kind == 0) act = {1'b0, gain_o};
      else              act = {9'b0, sdata_oe, sdata_o};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual 0x%0h expected 0x%0h", it.rq, it.kind, act, it.exp);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic probe(input string rq, input int kind, input logic [10:0] exp);
    item_t it;
    it.rq = rq; it.kind = kind; it.exp = exp;
    exp_q.push_back(it);
    mon_strobe = 1'b1;
    @(negedge clk);
    mon_strobe = 1'b0;
  endtask

  task automatic frame(input logic rnw, input logic [3:0] a, input logic [10:0] d,
                       input int nbits, input bit chk_rd, input bit chk_mid);
    sload_n = 1'b0;
    wait_n(H);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      logic eb;
      int idx;
      if (i == 0)      b = rnw;
      else if (i < 5)  b = a[i-1];
      else if (i < 16) b = d[i-5];
      else             b = 1'b1;
      sdata = b;
      wait_n(H-1);
      idx = i - 5;
      eb = (a == ADDR && idx >= 0 && idx < 10) ? model_gain[idx] : 1'b0;
      if (chk_rd && i >= 1 && i < 5)
        probe("R5", 1, 11'b0);
      else if (chk_rd && i >= 5 && i < 16)
        probe((a == ADDR) ? "R5" : "R6", 1, {9'b0, 1'b1, eb});
      else if (chk_mid && i == 10)
        probe("R3", 0, {1'b0, model_gain});
      else
        wait_n(1);
      sclk = 1'b1;
      wait_n(H);
      sclk = 1'b0;
    end
    wait_n(H);
    if (chk_mid) probe("R3", 0, {1'b0, model_gain});
    else         wait_n(1);
    sload_n = 1'b1;
    wait_n(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sload_n = 1'b1; sdata = 1'b0;
    model_gain = 10'h096;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);

    // R1: reset state
    probe("R1", 0, 11'h096);
    probe("R1", 1, 11'h000);

    // R7: full write during lockout is discarded
    frame(1'b0, ADDR, 11'h155, 16, 1'b0, 1'b0);
    probe("R7", 0, {1'b0, model_gain});
    wait_n(LOCK);

    // R3 and R2: held while shifting, committed after load rises
    frame(1'b0, ADDR, 11'h2C3, 16, 1'b0, 1'b1);
    model_gain = 10'h2C3;
    probe("R2", 0, {1'b0, model_gain});

    // R2: bit 10 of the data field is dropped
    frame(1'b0, ADDR, 11'h4F0, 16, 1'b0, 1'b0);
    model_gain = 10'h0F0;
    probe("R2", 0, {1'b0, model_gain});

    // R4: foreign address write ignored
    frame(1'b0, 4'h3, 11'h111, 16, 1'b0, 1'b0);
    probe("R4", 0, {1'b0, model_gain});

    // R8: short frame aborted
    frame(1'b0, ADDR, 11'h0AA, 10, 1'b0, 1'b0);
    probe("R8", 0, {1'b0, model_gain});

    // R10: surplus rising edges ignored
    frame(1'b0, ADDR, 11'h1A5, 19, 1'b0, 1'b0);
    model_gain = 10'h1A5;
    probe("R10", 0, {1'b0, model_gain});

    // R5: readback of own address, data field driven all ones
    frame(1'b1, ADDR, 11'h7FF, 16, 1'b1, 1'b0);
    probe("R9", 1, 11'h000);
    probe("R5", 0, {1'b0, model_gain});

    // R6: readback of foreign address returns zeros
    frame(1'b1, 4'h3, 11'h000, 16, 1'b1, 1'b0);
    probe("R9", 1, 11'h000);

    // R5 boundary: all ones, then all zeros
    frame(1'b0, ADDR, 11'h3FF, 16, 1'b0, 1'b0);
    model_gain = 10'h3FF;
    probe("R2", 0, {1'b0, model_gain});
    frame(1'b1, ADDR, 11'h000, 16, 1'b1, 1'b0);
    frame(1'b0, ADDR, 11'h000, 16, 1'b0, 1'b0);
    model_gain = 10'h000;
    probe("R2", 0, {1'b0, model_gain});
    frame(1'b1, ADDR, 11'h000, 16, 1'b1, 1'b0);
    probe("R9", 1, 11'h000);

    wait_n(4);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard R5 actual %0d pending expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule